// File: doc/BRIEF.md
# Cascaded Prescaler and Pulse Generator Pair

This block holds two 8-bit programmable pulse channels that share one machine clock. The first channel, the prescaler, counts down on each machine-clock cycle on which the count-clock enable input is high. It drives a pulse waveform whose period and high time are set by its own cycle and duty values. The second channel, the main generator, does not use the count-clock enable. It advances once for every level change of the prescaler's waveform, whether that change is rising or falling. A 50% prescaler waveform therefore gives the main channel a count clock at twice the prescaler's pulse rate.

Each channel has an enable pin, a polarity pin and two writable values, cycle and duty. Writes go through one shared port into buffer registers. A channel copies its buffers into its working registers only when it starts or when its counter reloads, so a period that is already under way always finishes with the settings it started with. All outputs come from registers. Control pins are plain levels, and the write port is a single-cycle strobe with no back-pressure: every strobe is accepted in the cycle it is asserted.

Top module: `cascade_ppg`

## Requirements
- R1: When a channel's enable goes high, its counter loads the buffered cycle value on the next clock. Each count then lowers the counter by one. The count that follows a counter value of 1 reloads the cycle value, so one period lasts cycle-value counts. A cycle value of 0 behaves like 1, a one-count period.
- R2: While a channel runs, its raw waveform is high exactly while the counter is at or below the active duty value. For 0 < duty < cycle, the high time is therefore duty counts out of every cycle counts.
- R3: A duty value of 0 keeps the raw waveform low for as long as the channel runs. A nonzero duty value at or above the cycle value keeps it high.
- R4: Each output pin equals the channel's raw waveform XOR its polarity pin. Polarity 1 inverts the pin and polarity 0 passes the raw waveform unchanged. This also applies while the channel is stopped.
- R5: A write strobe stores `wr_data` into a buffer chosen by `wr_addr`. Bit 1 of the address picks the channel (0 = prescaler, 1 = main) and bit 0 picks the value (0 = cycle, 1 = duty). A buffered value takes effect only at the channel's next start or reload, never partway through a period.
- R6: Clearing a channel's enable stops its counter and forces its raw waveform low on the next clock.
- R7: The main channel takes one count for every rising and every falling edge of the prescaler's raw waveform. It takes counts only while the prescaler is enabled. The example case is prescaler cycle 4, duty 2, main cycle 3, duty 2, with the count enable held high. It gives a main period of 6 clocks, high for 4 of them.
- R8: While the prescaler is stopped, or while it runs at 0% or 100% high time, the main channel's waveform holds its level. The main channel keeps its counter value during this time.
- R9: The prescaler counts only on clocks where `cnt_tick` is high. Every output change appears one clock after the count that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable for the prescaler channel |
| wr_en | input | 1 | Write strobe for the buffer registers |
| wr_addr | input | 2 | Buffer select: bit 1 channel, bit 0 cycle/duty |
| wr_data | input | 8 | Value to store |
| pre_en | input | 1 | Prescaler channel enable |
| main_en | input | 1 | Main channel enable |
| pre_inv | input | 1 | Prescaler output polarity (1 = inverted) |
| main_inv | input | 1 | Main output polarity (1 = inverted) |
| pre_out | output | 1 | Prescaler output pin |
| main_out | output | 1 | Main channel output pin |

## Verification
The prescaler is swept over every cycle value from 0 to 6 against every duty value from 0 to 7, and each run's measured period and high time are compared with the arithmetic. That sweep separates the pulse region from the constant-low and constant-high regions, and it separates a cycle of 0 from a cycle of 1. The main channel gets the same kind of sweep behind a 2-clock edge spacing and then behind a 1-clock edge spacing. Each run's timing must scale by the edge spacing, which shows that both edge directions count. Separate runs cover a stopped prescaler, a flat prescaler waveform, a halved tick rate, a held tick, inverted pins, and a duty write landing mid-period, which tells buffered loading apart from immediate loading.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Which buffered value a write addresses (address bit 0).
  typedef enum logic {
    SEL_CYCLE = 1'b0,
    SEL_DUTY  = 1'b1
  } reg_sel_e;

  // Number of cascaded channels; index 0 is the prescaler.
  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/ppg_bufs.sv
module ppg_bufs
  import ppg_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = NUM_CH,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned AW = CW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [W-1:0]          wr_data,
  output logic [NCH-1:0][W-1:0] cyc_buf,
  output logic [NCH-1:0][W-1:0] duty_buf
);

  logic [CW-1:0] ch_sel;
  reg_sel_e      val_sel;

  assign ch_sel  = wr_addr[AW-1:1];
  assign val_sel = reg_sel_e'(wr_addr[0]);

  for (genvar c = 0; c < NCH; c++) begin : g_buf
    logic hit;
    assign hit = wr_en && (ch_sel == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyc_buf[c]  <= '0;
        duty_buf[c] <= '0;
      end else if (hit) begin
        if (val_sel == SEL_CYCLE) cyc_buf[c]  <= wr_data;
        else                      duty_buf[c] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ppg_chan.sv
module ppg_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] cyc_buf,
  input  logic [W-1:0] duty_buf,
  output logic         raw
);

  logic         run_q;
  logic [W-1:0] cnt_q, cyc_q, duty_q;
  logic         raw_q;

  logic         start, reload;
  logic [W-1:0] cnt_d, cyc_d, duty_d;
  logic         raw_d;

  always_comb begin
    start  = en && !run_q;
    reload = start || (en && run_q && tick && (cnt_q <= W'(1)));
    cyc_d  = reload ? cyc_buf  : cyc_q;
    duty_d = reload ? duty_buf : duty_q;
    if (!en)          cnt_d = '0;
    else if (reload)  cnt_d = cyc_buf;
    else if (tick)    cnt_d = cnt_q - W'(1);
    else              cnt_d = cnt_q;
    // High while the count sits at or below the duty value.
    raw_d = en && (duty_d != '0) && (cnt_d <= duty_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      cyc_q  <= '0;
      duty_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      run_q  <= en;
      cnt_q  <= cnt_d;
      cyc_q  <= cyc_d;
      duty_q <= duty_d;
      raw_q  <= raw_d;
    end
  end

  assign raw = raw_q;

endmodule

// File: rtl/ppg_edge.sv
module ppg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic lvl,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // One pulse per level change in either direction, only while gated on.
  assign pulse = gate && (lvl != prev_q);

endmodule

// File: rtl/cascade_ppg.sv
module cascade_ppg
  import ppg_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned NCH = NUM_CH,
  localparam int unsigned AW  = $clog2(NCH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          pre_en,
  input  logic          main_en,
  input  logic          pre_inv,
  input  logic          main_inv,
  output logic          pre_out,
  output logic          main_out
);

  logic [NCH-1:0][W-1:0] cyc_buf, duty_buf;
  logic [NCH-1:0]        en_v, inv_v, tick_v, raw_v, pin_v;
  logic                  edge_pulse;

  assign en_v  = {main_en, pre_en};
  assign inv_v = {main_inv, pre_inv};

  ppg_bufs #(.W(W), .NCH(NCH)) u_bufs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cyc_buf  (cyc_buf),
    .duty_buf (duty_buf)
  );

  ppg_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (pre_en),
    .lvl   (raw_v[0]),
    .pulse (edge_pulse)
  );

  assign tick_v[0] = cnt_tick;
  assign tick_v[1] = edge_pulse;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ppg_chan #(.W(W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_v[c]),
      .tick     (tick_v[c]),
      .cyc_buf  (cyc_buf[c]),
      .duty_buf (duty_buf[c]),
      .raw      (raw_v[c])
    );
  end

  assign pin_v    = raw_v ^ inv_v;
  assign pre_out  = pin_v[0];
  assign main_out = pin_v[1];

endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         pre_en,
  input logic         main_en,
  input logic         pre_inv,
  input logic         pre_out,
  input logic         pre_raw,
  input logic         main_raw,
  input logic         pre_run,
  input logic [W-1:0] pre_cnt,
  input logic [W-1:0] pre_cyc,
  input logic [W-1:0] pre_duty
);

  // R6
  pre_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> (pre_out == pre_inv));

  // R6
  main_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |=> !main_raw);

  // R8
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pre_en) && $past(main_en) && $past(main_en, 2)) |-> $stable(main_raw));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_tick) && $past(pre_en) && $past(pre_en, 2)) |-> $stable(pre_raw));

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_run |-> (pre_cnt <= pre_cyc));

  // R3
  duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_run && (pre_duty == '0)) |-> !pre_raw);

  // R3
  duty_full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_run && (pre_duty != '0) && (pre_duty >= pre_cyc)) |-> pre_raw);

endmodule

bind cascade_ppg ppg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_tick (cnt_tick),
  .pre_en   (pre_en),
  .main_en  (main_en),
  .pre_inv  (pre_inv),
  .pre_out  (pre_out),
  .pre_raw  (g_ch[0].u_chan.raw_q),
  .main_raw (g_ch[1].u_chan.raw_q),
  .pre_run  (g_ch[0].u_chan.run_q),
  .pre_cnt  (g_ch[0].u_chan.cnt_q),
  .pre_cyc  (g_ch[0].u_chan.cyc_q),
  .pre_duty (g_ch[0].u_chan.duty_q)
);

// File: tb/cascade_ppg_tb.sv
module cascade_ppg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pre_en = 1'b0, main_en = 1'b0;
  logic       pre_inv = 1'b0, main_inv = 1'b0;
  logic       pre_out, main_out;

  int n_chk = 0;
  int n_fail = 0;
  int tick_mode = 0;   // 0 always, 1 every other clock, 2 manual
  logic smp [0:63];

  always #10 clk = ~clk;

  cascade_ppg u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pre_en(pre_en), .main_en(main_en), .pre_inv(pre_inv), .main_inv(main_inv),
    .pre_out(pre_out), .main_out(main_out)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (tick_mode == 0)      cnt_tick = 1'b1;
      else if (tick_mode == 1) cnt_tick = ~cnt_tick;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int pm, input int pn, input int mm, input int mn,
                       input logic pe, input logic me);
    @(negedge clk);
    pre_en = 1'b0; main_en = 1'b0;
    repeat (2) @(negedge clk);
    wr(2'd0, 8'(pm)); wr(2'd1, 8'(pn));
    wr(2'd2, 8'(mm)); wr(2'd3, 8'(mn));
    @(negedge clk);
    pre_en = pe; main_en = me;
  endtask

  // Sample one output for 64 clocks after settling; extract period and high time.
  task automatic measure(input bit which, output int per, output int hi,
                         output bit flat, output bit lvl);
    int r1, r2;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      smp[i] = which ? main_out : pre_out;
      @(negedge clk);
    end
    r1 = -1; r2 = -1;
    for (int i = 1; i < 64; i++)
      if (smp[i] && !smp[i-1]) begin
        if (r1 < 0) r1 = i;
        else if (r2 < 0) r2 = i;
      end
    flat = (r2 < 0); lvl = smp[0]; per = 0; hi = 0;
    if (flat) begin
      for (int i = 1; i < 64; i++) if (smp[i] != smp[0]) flat = 1'b0;
    end else begin
      per = r2 - r1;
      for (int i = r1; i < r2; i++) hi += int'(smp[i]);
    end
  endtask

  // Expected waveform from cycle m, duty n, k clocks per count, inversion inv.
  task automatic expect_wave(input string tag, input bit which, input int m, input int n,
                             input int k, input bit inv);
    int per, hi;
    bit flat, lvl;
    measure(which, per, hi, flat, lvl);
    if (n == 0) begin
      chk({tag, " flat-low"}, int'(flat), 1);
      chk({tag, " level"}, int'(lvl), int'(inv));
    end else if (n >= m) begin
      chk({tag, " flat-high"}, int'(flat), 1);
      chk({tag, " level"}, int'(lvl), int'(!inv));
    end else begin
      chk({tag, " period"}, per, m * k);
      chk({tag, " high"}, hi, inv ? (m - n) * k : n * k);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per, hi;
    bit flat, lvl;
    repeat (3) @(negedge clk);
    // R6: reset state, both outputs low
    chk("R6 reset pre_out", int'(pre_out), 0);
    chk("R6 reset main_out", int'(main_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: prescaler sweep, one tick per clock
    for (int m = 0; m <= 6; m++)
      for (int n = 0; n <= 7; n++) begin
        setup(m, n, 3, 1, 1'b1, 1'b0);
        expect_wave($sformatf("R1/R2/R3 pre m=%0d n=%0d", m, n), 1'b0, m, n, 1, 1'b0);
      end

    // R9: ticks on every other clock double the timing
    tick_mode = 1;
    setup(3, 1, 3, 1, 1'b1, 1'b0);
    expect_wave("R9 half-rate", 1'b0, 3, 1, 2, 1'b0);
    tick_mode = 0;

    // R4: inverted prescaler pin
    pre_inv = 1'b1;
    setup(5, 2, 3, 1, 1'b1, 1'b0);
    expect_wave("R4 pre inverted", 1'b0, 5, 2, 1, 1'b1);
    pre_inv = 1'b0;

    // R7: main channel sweep behind a 4/2 prescaler (edges every 2 clocks)
    for (int m = 0; m <= 5; m++)
      for (int n = 0; n <= 6; n++) begin
        setup(4, 2, m, n, 1'b1, 1'b1);
        expect_wave($sformatf("R7 main m=%0d n=%0d", m, n), 1'b1, m, n, 2, 1'b0);
      end
    // R7: example configuration, period 6 high 4
    setup(4, 2, 3, 2, 1'b1, 1'b1);
    expect_wave("R7 example", 1'b1, 3, 2, 2, 1'b0);
    // R7: 2/1 prescaler gives an edge every clock
    setup(2, 1, 5, 2, 1'b1, 1'b1);
    expect_wave("R7 edge per clock", 1'b1, 5, 2, 1, 1'b0);
    // R4: inverted main pin
    main_inv = 1'b1;
    setup(4, 2, 3, 2, 1'b1, 1'b1);
    expect_wave("R4 main inverted", 1'b1, 3, 2, 2, 1'b1);
    main_inv = 1'b0;

    // R8: prescaler stopped, main holds its start level (cycle 3 duty 2 -> low)
    setup(4, 2, 3, 2, 1'b0, 1'b1);
    measure(1'b1, per, hi, flat, lvl);
    chk("R8 pre stopped flat", int'(flat), 1);
    chk("R8 pre stopped level", int'(lvl), 0);
    // R8: prescaler at 0% duty
    setup(4, 0, 3, 2, 1'b1, 1'b1);
    measure(1'b1, per, hi, flat, lvl);
    chk("R8 pre 0pct flat", int'(flat), 1);
    chk("R8 pre 0pct level", int'(lvl), 0);
    // R8: prescaler at 100% duty, settled before main starts
    setup(4, 4, 3, 2, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    main_en = 1'b1;
    measure(1'b1, per, hi, flat, lvl);
    chk("R8 pre 100pct flat", int'(flat), 1);
    chk("R8 pre 100pct level", int'(lvl), 0);

    // R5/R9: buffered duty write with manual ticks
    tick_mode = 2;
    setup(4, 2, 3, 1, 1'b0, 1'b0);
    @(negedge clk); cnt_tick = 1'b0;
    pre_en = 1'b1;
    @(negedge clk);
    chk("R1 start count 4 low", int'(pre_out), 0);
    wr(2'd1, 8'd0);
    repeat (6) @(negedge clk);
    chk("R9 held tick no change", int'(pre_out), 0);
    pulse_tick();              // count 3
    chk("R2 count 3 low", int'(pre_out), 0);
    pulse_tick();              // count 2, old duty 2 still active
    chk("R5 old duty kept mid-period", int'(pre_out), 1);
    pulse_tick();              // count 1
    chk("R2 count 1 high", int'(pre_out), 1);
    pulse_tick();              // reload, duty 0 now active
    chk("R5 new duty at reload", int'(pre_out), 0);
    for (int i = 0; i < 4; i++) begin
      pulse_tick();
      chk("R3 duty 0 stays low", int'(pre_out), 0);
    end

    // R6: disable while high, with and without inversion
    tick_mode = 0;
    setup(4, 3, 3, 1, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    while (pre_out != 1'b1) @(negedge clk);
    pre_en = 1'b0;
    @(negedge clk);
    chk("R6 stop forces low", int'(pre_out), 0);
    pre_inv = 1'b1;
    #1;
    chk("R6 stopped pin inverted", int'(pre_out), 1);
    repeat (5) @(negedge clk);
    chk("R6 stays stopped", int'(pre_out), 1);
    pre_inv = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule